// File: doc/BRIEF.md
# Controller Presence Debouncer

This block decides whether a game controller is plugged into a three-wire serial pad port by looking at the resting level of the data line. The line has a pull-up, so an empty port rests high. An attached controller drives the line low while it is idle. Just before each poll trigger, and while no serial read is running, the host logic pulses a sample strobe and presents the line level. The block measures how long that level has stayed the same, using a free-running 1 µs tick. It only changes its verdict once the level has been steady for a long window, 500 ms by default.

The block also sits in the path of the button byte produced by the serial reader. While a controller is attached, each sample strobe yields a one-cycle report carrying the current button byte. When the controller is judged removed, the block emits exactly one report with every button released, so nothing stays stuck pressed. After that it stays silent, with a zero button output, until a controller is detected again. Because the strobe can come far more often than the poll rate, the window is counted in elapsed time, not in number of samples.

Top module: `presence_debouncer`

## Requirements
- R1: After reset, `connected` is 0, `btn_out` is all zeros and `report_stb` is 0. The elapsed-time count starts at zero with a high (empty) candidate level.
- R2: `connected` becomes 1 at a sample strobe whose level is low, when at least `HOLD_US` ticks have arrived since the low level was first seen. The flag is visible in the cycle after the strobe.
- R3: A low level held for fewer than `HOLD_US` ticks does not set `connected`.
- R4: A sample whose level differs from the current candidate makes that level the new candidate and restarts the elapsed count at zero.
- R5: `connected` falls to 0 at a sample strobe whose level is high, when at least `HOLD_US` ticks have arrived since the high level was first seen.
- R6: On the fall of `connected`, `report_stb` pulses for one cycle with `btn_out` equal to all zeros.
- R7: While `connected` is 1 after a sample strobe, `report_stb` pulses high for one cycle following that strobe, with `btn_out` equal to the `btn_raw` presented with it. Bit i of the byte is button i, and 1 means pressed.
- R8: While disconnected, `btn_out` stays all zeros and no report is issued, apart from the single clearing report of R6, whatever `btn_raw` carries.
- R9: The elapsed count saturates at `HOLD_US` and does not wrap, so a level held far beyond the window still qualifies.
- R10: Debouncing depends on elapsed ticks only. Any number of sample strobes without ticks never changes `connected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| sample_stb | input | 1 | Idle-level sample strobe, pulsed before each poll trigger |
| line_lvl | input | 1 | Resting data-line level with the strobe (1 = high) |
| btn_raw | input | BTN_W | Button byte from the serial reader, 1 = pressed |
| connected | output | 1 | Debounced presence flag |
| btn_out | output | BTN_W | Gated button byte |
| report_stb | output | 1 | One-cycle report strobe |

## Verification
The bench places the connect check one tick short of the window and again exactly at it. A design that counts one tick too many or too few would connect early or late. A brief high glitch during a long low stretch, followed by a restart, tests the restart rule: a design that keeps counting across a disagreement would drop the controller too soon. A low level held for twice the counter's range exposes a wrapping counter, which would fail to connect. A burst of strobes with no ticks catches a design that counts samples instead of time. Pressed buttons are driven while the port is empty, so a design that leaks them or issues extra reports is caught, and the single all-zero report at disconnect is compared item by item in the scoreboard.

// File: rtl/presence_debouncer_pkg.sv
package presence_debouncer_pkg;

  typedef enum logic {
    PRES_DETACHED = 1'b0,
    PRES_ATTACHED = 1'b1
  } pres_state_e;

  // A resting high level means the pull-up wins: nothing is plugged in.
  function automatic pres_state_e level_to_state(input logic lvl);
    return lvl ? PRES_DETACHED : PRES_ATTACHED;
  endfunction

endpackage

// File: rtl/pd_elapsed_timer.sv
module pd_elapsed_timer #(
  parameter int LIMIT = 500000,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic at_limit
);

  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] elapsed_q;

  assign at_limit = (elapsed_q == LIMIT_C);

  // A restart has priority over a tick arriving in the same cycle.
  // Once the limit is reached, the count holds there.
  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed_q <= '0;
    end else if (clear) begin
      elapsed_q <= '0;
    end else if (tick && !at_limit) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

endmodule

// File: rtl/pd_presence_fsm.sv
module pd_presence_fsm
  import presence_debouncer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sample_stb,
  input  logic        line_lvl,
  input  logic        at_limit,
  output logic        timer_clear,
  output pres_state_e state,
  output logic        evt_report,
  output logic        evt_clear
);

  logic        cand_q;
  pres_state_e state_q;
  pres_state_e state_d;
  logic        mismatch;
  logic        settle;

  assign mismatch    = sample_stb && (line_lvl != cand_q);
  assign settle      = sample_stb && !mismatch && at_limit;
  assign timer_clear = mismatch;

  always_comb begin
    state_d = state_q;
    if (settle) begin
      state_d = level_to_state(cand_q);
    end
  end

  // Report events are decided from the state that follows this strobe.
  assign evt_report = sample_stb && (state_d == PRES_ATTACHED);
  assign evt_clear  = sample_stb && (state_q == PRES_ATTACHED) &&
                      (state_d == PRES_DETACHED);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q  <= 1'b1;
      state_q <= PRES_DETACHED;
    end else begin
      if (mismatch) begin
        cand_q <= line_lvl;
      end
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/pd_report_gate.sv
module pd_report_gate #(
  parameter int BTN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_report,
  input  logic             evt_clear,
  input  logic [BTN_W-1:0] btn_raw,
  output logic [BTN_W-1:0] btn_out,
  output logic             report_stb
);

  logic [BTN_W-1:0] btn_q;
  logic             stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= evt_report || evt_clear;
      if (evt_report) begin
        btn_q <= btn_raw;
      end else if (evt_clear) begin
        btn_q <= '0;
      end
    end
  end

  assign btn_out    = btn_q;
  assign report_stb = stb_q;

endmodule

// File: rtl/presence_debouncer.sv
module presence_debouncer
  import presence_debouncer_pkg::*;
#(
  parameter int HOLD_US = 500000,
  parameter int BTN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_us,
  input  logic             sample_stb,
  input  logic             line_lvl,
  input  logic [BTN_W-1:0] btn_raw,
  output logic             connected,
  output logic [BTN_W-1:0] btn_out,
  output logic             report_stb
);

  logic        timer_clear;
  logic        at_limit;
  logic        evt_report;
  logic        evt_clear;
  pres_state_e state;

  pd_elapsed_timer #(
    .LIMIT(HOLD_US)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (timer_clear),
    .tick    (tick_us),
    .at_limit(at_limit)
  );

  pd_presence_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .line_lvl   (line_lvl),
    .at_limit   (at_limit),
    .timer_clear(timer_clear),
    .state      (state),
    .evt_report (evt_report),
    .evt_clear  (evt_clear)
  );

  pd_report_gate #(
    .BTN_W(BTN_W)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .evt_report(evt_report),
    .evt_clear (evt_clear),
    .btn_raw   (btn_raw),
    .btn_out   (btn_out),
    .report_stb(report_stb)
  );

  assign connected = (state == PRES_ATTACHED);

endmodule

// File: rtl/presence_debouncer_chk.sv
module presence_debouncer_chk #(
  parameter int BTN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_stb,
  input logic             line_lvl,
  input logic [BTN_W-1:0] btn_raw,
  input logic             connected,
  input logic [BTN_W-1:0] btn_out,
  input logic             report_stb
);

  // R2: a connect is only ever caused by a low sample
  assert_rise_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(connected) |-> ($past(sample_stb) && !$past(line_lvl)));

  // R5: a disconnect is only ever caused by a high sample
  assert_fall_high_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(connected) |-> ($past(sample_stb) && $past(line_lvl)));

  // R6: the disconnect carries a released-button report
  assert_clear_report_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(connected) |-> (report_stb && btn_out == '0));

  // R7: a connected report carries the byte given with the strobe
  assert_report_data_R7: assert property (@(posedge clk) disable iff (rst)
    (report_stb && connected) |-> (btn_out == $past(btn_raw)));

  // R7: reports only follow a sample strobe
  assert_report_cause_R7: assert property (@(posedge clk) disable iff (rst)
    report_stb |-> $past(sample_stb));

  // R8: nothing leaks while the port is judged empty
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !connected |-> (btn_out == '0));

  // R10: the flag moves only right after a strobe
  assert_moves_on_sample_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(connected) |-> $past(sample_stb));

endmodule

bind presence_debouncer presence_debouncer_chk #(.BTN_W(BTN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_stb(sample_stb),
  .line_lvl  (line_lvl),
  .btn_raw   (btn_raw),
  .connected (connected),
  .btn_out   (btn_out),
  .report_stb(report_stb)
);

// File: tb/presence_debouncer_bench.sv
module presence_debouncer_bench;

  localparam int HOLD  = 20;
  localparam int BTN_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_us = 1'b0;
  logic             sample_stb = 1'b0;
  logic             line_lvl = 1'b1;
  logic [BTN_W-1:0] btn_raw = '0;
  logic             connected;
  logic [BTN_W-1:0] btn_out;
  logic             report_stb;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model, built from the requirements
  logic m_cand = 1'b1;
  int   m_cnt  = 0;
  logic m_conn = 1'b0;

  logic [BTN_W-1:0] exp_q[$];

  always #5 clk = ~clk;

  presence_debouncer #(.HOLD_US(HOLD), .BTN_W(BTN_W)) u_presence_debouncer (
    .clk       (clk),
    .rst       (rst),
    .tick_us   (tick_us),
    .sample_stb(sample_stb),
    .line_lvl  (line_lvl),
    .btn_raw   (btn_raw),
    .connected (connected),
    .btn_out   (btn_out),
    .report_stb(report_stb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_us = 1'b1;
      @(negedge clk) tick_us = 1'b0;
      if (m_cnt < HOLD) m_cnt++;
    end
  endtask

  // Driver: one strobe; pushes the expected report, then checks the flag
  task automatic sample(input logic lvl, input logic [BTN_W-1:0] b, input string req);
    logic was;
    was = m_conn;
    if (lvl != m_cand) begin
      m_cand = lvl;
      m_cnt  = 0;
    end else if (m_cnt >= HOLD) begin
      m_conn = !lvl;
    end
    if (m_conn) exp_q.push_back(b);
    else if (was) exp_q.push_back('0);
    @(negedge clk);
    sample_stb = 1'b1;
    line_lvl   = lvl;
    btn_raw    = b;
    @(negedge clk);
    sample_stb = 1'b0;
    check({req, " connected"}, 32'(connected), 32'(m_conn));
    if (!m_conn) check("R8 btn_out zero while empty", 32'(btn_out), 0);
  endtask

  // Monitor: pops an expected report for every strobe seen
  always @(negedge clk) begin
    if (!rst && report_stb) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R8 unexpected report: actual %0h expected none", btn_out);
      end else begin
        check("R6/R7 report byte", 32'(btn_out), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 connected after reset", 32'(connected), 0);
    check("R1 btn_out after reset", 32'(btn_out), 0);
    check("R1 report_stb after reset", 32'(report_stb), 0);

    // R10: many strobes, no ticks
    for (int i = 0; i < 30; i++) sample(1'b0, 8'hFF, "R10 no ticks");

    // R3 then R2: one tick short, then exactly at the window
    ticks(HOLD - 1);
    sample(1'b0, 8'h81, "R3 short hold");
    ticks(1);
    sample(1'b0, 8'h81, "R2 connect at window");

    // R7: reports follow button patterns
    sample(1'b0, 8'h00, "R7 no buttons");
    sample(1'b0, 8'h5A, "R7 pattern 5A");
    ticks(3);
    sample(1'b0, 8'hA5, "R7 pattern A5");

    // R4: glitch high then restart
    sample(1'b1, 8'h10, "R4 glitch high");
    ticks(15);
    sample(1'b0, 8'h20, "R4 back low");
    sample(1'b1, 8'h40, "R4 high again");
    ticks(15);
    sample(1'b1, 8'h40, "R4 restart kept connected");

    // R5/R6: disconnect with a clearing report
    ticks(10);
    sample(1'b1, 8'hFF, "R5 disconnect");

    // R8: pressed buttons on an empty port
    ticks(5);
    sample(1'b1, 8'hFF, "R8 empty with buttons");
    sample(1'b1, 8'h3C, "R8 empty with buttons");

    // R9: hold far past the counter range
    sample(1'b0, 8'h00, "R9 start low");
    ticks(2 * 32);
    sample(1'b0, 8'hC3, "R9 saturated connect");

    repeat (4) @(negedge clk);
    check("R6/R7 all reports seen", 32'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule